// File: doc/BRIEF.md
# Keyed-Unlock Watchdog Timer

This block is a watchdog timer reached over a small register bus. It has four word registers: a control register, a timeout limit, a window limit and a counter. The counter counts up every clock while the watchdog runs. When the counter reaches the timeout limit, the block raises a one-cycle reset pulse. Software keeps the watchdog quiet by writing a two-part refresh key into the counter register. In window mode, a refresh that arrives too early is treated as a fault.

After reset the configuration is open. Software writes its settings once, and they take effect only when every required register has been written. From then on the configuration is locked. It can be reopened only by writing a keyed unlock sequence to the counter register, and only if the update-allow bit was part of the committed settings. Keys arrive either as two halfword writes that must follow each other closely, or as a single full-word write when the full-word command bit is set. Any malformed, out-of-order or late key causes an immediate reset pulse.

Top module: `wdt_keyguard`

Register offsets on `bus_addr`: 0 control, 1 timeout, 2 window, 3 counter. Control bits: bit 0 run, bit 1 window mode, bit 2 update-allow, bit 3 full-word commands. Two further control bits are read-only: bit 4 reads 1 while the configuration is open, and bit 5 reads 1 once any configuration has been committed.

## Requirements
- R1: After reset the control register reads 0x11 (run set, configuration open). The timeout register reads `DEF_TOVAL`, and the window and counter registers read 0.
- R2: While run is set, the counter rises by one per clock. Once the counter is at or above the timeout limit, `wdt_rst_o` is high for exactly the next cycle and the counter returns to 0.
- R3: A configuration commits only after the control and timeout registers have been written, plus the window register if the staged control word has window mode set. Until the commit, every register reads its previous active value.
- R4: While the configuration is closed, writes to the control, timeout and window registers leave their read values unchanged.
- R5: In halfword mode, the halfword 0xC520 followed by the halfword 0xD928, with the second write at most `KEY_DEADLINE` clocks after the first, reopens a committed configuration whose update-allow bit is set. It raises no reset pulse, and control bit 4 reads 1.
- R6: In halfword mode, each of the following raises a reset pulse: an unknown first halfword, 0xD928 sent first, a second halfword that does not match, a missing second halfword after `KEY_DEADLINE` clocks, or a full-word key write.
- R7: With control bit 3 set, a full-word write of 0xD928C520 unlocks, a full-word write of 0xB480A602 refreshes, and any halfword key write raises a reset pulse.
- R8: An unlocked configuration that is not committed within `UNLOCK_WIN` clocks closes again, and its staged writes are discarded.
- R9: A refresh (the halfword pair 0xA602 then 0xB480, or the full word in full-word mode) clears the counter, so the next timeout pulse appears `DEF`-independent, exactly timeout+1 clocks after the refresh edge.
- R10: In window mode, a refresh that arrives while the counter is below the window limit raises a reset pulse. A refresh at or above the limit raises none.
- R11: A correct unlock key sent to a committed configuration without update-allow raises a reset pulse and leaves the configuration closed and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register select |
| bus_strb | input | 4 | Byte strobes; 0011 or 1100 marks a halfword key, 1111 a full-word key |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| wdt_rst_o | output | 1 | One-cycle watchdog reset pulse |

## Verification
A key write captured at a clock edge shows its effect on `wdt_rst_o` at that same edge, so the bench counts pulses two falling edges after each write. A configuration commit lands one edge after the last required write, and the bench reads registers two cycles later. For timeouts, the bench counts falling edges after the refresh edge and expects the first pulse on count timeout+1 and none before it. The unlock deadline is driven at exactly `KEY_DEADLINE` clocks of spacing and at one more than that. The unlock window is sampled well before and well after `UNLOCK_WIN` clocks.

// File: rtl/wdt_keyguard_pkg.sv
package wdt_keyguard_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Control word as stored; bit order is visible at the bus
    typedef struct packed {
        logic cmd32;
        logic upd_ok;
        logic win_en;
        logic run;
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{cmd32: 1'b0, upd_ok: 1'b0, win_en: 1'b0, run: 1'b1};

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_TOUT = 2'd1,
        REG_WIN  = 2'd2,
        REG_CNT  = 2'd3
    } reg_e;

    typedef enum logic [1:0] {
        KS_IDLE,
        KS_UNL,
        KS_REF
    } ks_e;

    typedef struct packed {
        logic unlock;
        logic refresh;
        logic fault;
    } key_ev_t;

    localparam logic [15:0] UNL_LO = 16'hC520;
    localparam logic [15:0] UNL_HI = 16'hD928;
    localparam logic [15:0] REF_LO = 16'hA602;
    localparam logic [15:0] REF_HI = 16'hB480;

    function automatic logic [31:0] pair32(input logic [15:0] hi, input logic [15:0] lo);
        return {hi, lo};
    endfunction
endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_keyguard_pkg::*;
#(
    parameter int DEADLINE = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        mode32,
    input  logic        cmd16_v,
    input  logic        cmd32_v,
    input  logic [31:0] cmd_word,
    output key_ev_t     ev
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WAIT_W = $clog2(DEADLINE + 1);

    ks_e               st_q, st_d;
    logic [WAIT_W-1:0] wait_q, wait_d;
    logic [15:0]       half;

    assign half = cmd_word[15:0];

    always_comb begin
        ev     = '0;
        st_d   = st_q;
        wait_d = '0;
        if (mode32) begin
            st_d = KS_IDLE;
            if (cmd32_v) begin
                if (cmd_word == pair32(UNL_HI, UNL_LO))      ev.unlock  = 1'b1;
                else if (cmd_word == pair32(REF_HI, REF_LO)) ev.refresh = 1'b1;
                else                                         ev.fault   = 1'b1;
            end else if (cmd16_v) begin
                ev.fault = 1'b1;
            end
        end else begin
            unique case (st_q)
                KS_IDLE: begin
                    if (cmd32_v) begin
                        ev.fault = 1'b1;
                    end else if (cmd16_v) begin
                        if (half == UNL_LO)      st_d = KS_UNL;
                        else if (half == REF_LO) st_d = KS_REF;
                        else                     ev.fault = 1'b1;
                    end
                end
                default: begin
                    if (cmd16_v || cmd32_v) begin
                        st_d = KS_IDLE;
                        if (cmd16_v && st_q == KS_UNL && half == UNL_HI)      ev.unlock  = 1'b1;
                        else if (cmd16_v && st_q == KS_REF && half == REF_HI) ev.refresh = 1'b1;
                        else                                                  ev.fault   = 1'b1;
                    end else if (wait_q == WAIT_W'(DEADLINE - 1)) begin
                        st_d     = KS_IDLE;
                        ev.fault = 1'b1;
                    end else begin
                        wait_d = wait_q + 1'b1;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= KS_IDLE;
            wait_q <= '0;
        end else begin
            st_q   <= st_d;
            wait_q <= wait_d;
        end
    end

    // R6
    deadline_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q != KS_IDLE) |-> (wait_q < WAIT_W'(DEADLINE)));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_keyguard_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DEF_TOVAL  = 200,
    parameter int UNLOCK_WIN = 128,
    parameter int STRB_W     = (CNT_W + 7) / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_v,
    input  reg_e              wr_sel,
    input  logic [STRB_W-1:0] wr_strb,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              unlock_req,
    output ctrl_t             act_ctrl,
    output logic [CNT_W-1:0]  act_tout,
    output logic [CNT_W-1:0]  act_win,
    output logic              open_o,
    output logic              done_o,
    output logic              denied_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TMR_W = $clog2(UNLOCK_WIN + 1);

    ctrl_t             stg_ctrl, m_ctrl;
    logic [CNT_W-1:0]  stg_tout, stg_win, m_tout, m_win;
    logic              f_ctrl, f_tout, f_win;
    logic              open_q, done_q;
    logic [TMR_W-1:0]  tmr_q;
    logic              commit, reopen;

    // byte-strobe merge of a write onto the staged copies
    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            m_tout[b] = wr_strb[b/8] ? wr_data[b] : stg_tout[b];
            m_win[b]  = wr_strb[b/8] ? wr_data[b] : stg_win[b];
        end
        m_ctrl = wr_strb[0] ? ctrl_t'(wr_data[3:0]) : stg_ctrl;
    end

    assign commit   = open_q && f_ctrl && f_tout && (f_win || !stg_ctrl.win_en);
    assign reopen   = unlock_req && done_q && act_ctrl.upd_ok;
    assign denied_o = unlock_req && done_q && !act_ctrl.upd_ok;
    assign open_o   = open_q;
    assign done_o   = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_ctrl <= CTRL_DEFAULT;
            act_tout <= CNT_W'(DEF_TOVAL);
            act_win  <= '0;
            stg_ctrl <= CTRL_DEFAULT;
            stg_tout <= CNT_W'(DEF_TOVAL);
            stg_win  <= '0;
            f_ctrl   <= 1'b0;
            f_tout   <= 1'b0;
            f_win    <= 1'b0;
            open_q   <= 1'b1;
            done_q   <= 1'b0;
            tmr_q    <= '0;
        end else if (commit) begin
            act_ctrl <= stg_ctrl;
            act_tout <= stg_tout;
            act_win  <= stg_win;
            open_q   <= 1'b0;
            done_q   <= 1'b1;
            f_ctrl   <= 1'b0;
            f_tout   <= 1'b0;
            f_win    <= 1'b0;
        end else if (reopen) begin
            open_q   <= 1'b1;
            tmr_q    <= '0;
            stg_ctrl <= act_ctrl;
            stg_tout <= act_tout;
            stg_win  <= act_win;
            f_ctrl   <= 1'b0;
            f_tout   <= 1'b0;
            f_win    <= 1'b0;
        end else if (open_q && done_q && tmr_q == TMR_W'(UNLOCK_WIN - 1)) begin
            open_q <= 1'b0;
            f_ctrl <= 1'b0;
            f_tout <= 1'b0;
            f_win  <= 1'b0;
        end else if (open_q) begin
            if (done_q) tmr_q <= tmr_q + 1'b1;
            if (wr_v) begin
                unique case (wr_sel)
                    REG_CTRL: begin stg_ctrl <= m_ctrl; f_ctrl <= 1'b1; end
                    REG_TOUT: begin stg_tout <= m_tout; f_tout <= 1'b1; end
                    REG_WIN:  begin stg_win  <= m_win;  f_win  <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end

    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !open_q |=> ($stable(act_ctrl) && $stable(act_tout) && $stable(act_win)));

    // R8
    open_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (open_q && done_q) |-> (tmr_q < TMR_W'(UNLOCK_WIN)));

    // R3
    commit_flags_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(f_ctrl && f_tout));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             win_en,
    input  logic [CNT_W-1:0] tout,
    input  logic [CNT_W-1:0] win,
    input  logic             refresh,
    input  logic             fault_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             bite_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CNT_W-1:0] cnt_q;
    logic             bite_q;
    logic             expire, early, bite_d;

    assign expire = run && (cnt_q >= tout);
    assign early  = refresh && win_en && (cnt_q < win);
    assign bite_d = expire || early || fault_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            bite_q <= 1'b0;
        end else begin
            bite_q <= bite_d;
            if (bite_d || refresh || !run) cnt_q <= '0;
            else                           cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign bite_o = bite_q;

    // R2
    cleared_after_bite_chk: assert property (@(posedge clk) disable iff (rst)
        bite_q |-> (cnt_q == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !bite_d && !refresh) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/wdt_keyguard.sv
module wdt_keyguard
    import wdt_keyguard_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int DEF_TOVAL    = 200,
    parameter int KEY_DEADLINE = 16,
    parameter int UNLOCK_WIN   = 128
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [1:0]  bus_addr,
    input  logic [3:0]  bus_strb,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int STRB_W = (CNT_W + 7) / 8;

    reg_e             sel;
    logic             key_hit, cmd16_v, cmd32_v, cfg_we;
    logic [31:0]      key_word;
    key_ev_t          key_ev;
    ctrl_t            act_ctrl;
    logic [CNT_W-1:0] act_tout, act_win, cnt;
    logic             cfg_open, cfg_done, denied;

    assign sel      = reg_e'(bus_addr);
    assign key_hit  = bus_we && (sel == REG_CNT);
    assign cmd16_v  = key_hit && (bus_strb == 4'b0011 || bus_strb == 4'b1100);
    assign cmd32_v  = key_hit && (bus_strb == 4'b1111);
    assign cfg_we   = bus_we && (sel != REG_CNT);
    assign key_word = cmd32_v     ? bus_wdata :
                      bus_strb[2] ? {16'h0000, bus_wdata[31:16]} :
                                    {16'h0000, bus_wdata[15:0]};

    wdt_keyseq #(.DEADLINE(KEY_DEADLINE)) u_keys (
        .clk      (clk),
        .rst      (rst),
        .mode32   (act_ctrl.cmd32),
        .cmd16_v  (cmd16_v),
        .cmd32_v  (cmd32_v),
        .cmd_word (key_word),
        .ev       (key_ev)
    );

    wdt_cfg #(
        .CNT_W      (CNT_W),
        .DEF_TOVAL  (DEF_TOVAL),
        .UNLOCK_WIN (UNLOCK_WIN),
        .STRB_W     (STRB_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .wr_v       (cfg_we),
        .wr_sel     (sel),
        .wr_strb    (bus_strb[STRB_W-1:0]),
        .wr_data    (bus_wdata[CNT_W-1:0]),
        .unlock_req (key_ev.unlock),
        .act_ctrl   (act_ctrl),
        .act_tout   (act_tout),
        .act_win    (act_win),
        .open_o     (cfg_open),
        .done_o     (cfg_done),
        .denied_o   (denied)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .run      (act_ctrl.run),
        .win_en   (act_ctrl.win_en),
        .tout     (act_tout),
        .win      (act_win),
        .refresh  (key_ev.refresh),
        .fault_in (key_ev.fault || denied),
        .cnt_o    (cnt),
        .bite_o   (wdt_rst_o)
    );

    always_comb begin
        unique case (sel)
            REG_CTRL: bus_rdata = {26'd0, cfg_done, cfg_open, act_ctrl};
            REG_TOUT: bus_rdata = 32'(act_tout);
            REG_WIN:  bus_rdata = 32'(act_win);
            default:  bus_rdata = 32'(cnt);
        endcase
    end

    // R6
    fault_bite_chk: assert property (@(posedge clk) disable iff (rst)
        key_ev.fault |=> wdt_rst_o);

    // R11
    denied_bite_chk: assert property (@(posedge clk) disable iff (rst)
        denied |=> (wdt_rst_o && !cfg_open));

    // R10
    early_refresh_chk: assert property (@(posedge clk) disable iff (rst)
        (key_ev.refresh && act_ctrl.win_en && cnt < act_win) |=> wdt_rst_o);

    // R9
    refresh_clear_chk: assert property (@(posedge clk) disable iff (rst)
        key_ev.refresh |=> (cnt == '0));
endmodule

// File: tb/wdt_keyguard_test.sv
module wdt_keyguard_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W     = 16;
    localparam int DEF_TOVAL = 200;
    localparam int DEADLINE  = 16;
    localparam int WIN_LEN   = 128;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [3:0]  bus_strb = 4'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o;

    int nvec = 0;
    int nerr = 0;
    int bites = 0;
    int b0;
    logic [31:0] v;

    always #2.5 clk = ~clk;

    wdt_keyguard #(
        .CNT_W        (CNT_W),
        .DEF_TOVAL    (DEF_TOVAL),
        .KEY_DEADLINE (DEADLINE),
        .UNLOCK_WIN   (WIN_LEN)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_strb  (bus_strb),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_rst_o (wdt_rst_o)
    );

    always @(negedge clk) if (!rst && wdt_rst_o) bites++;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [3:0] s, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_strb = s; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input logic [1:0] a, input logic [31:0] exp, input string req);
        logic [31:0] got;
        rd(a, got);
        check(got == exp, req, got, exp);
    endtask

    task automatic expect_bites(input int exp, input string req);
        check(bites == exp, req, 32'(bites), 32'(exp));
    endtask

    task automatic unlock16(input int gap);
        wr(2'd3, 4'b0011, 32'h0000C520);
        idle(gap - 1);
        wr(2'd3, 4'b0011, 32'h0000D928);
    endtask

    task automatic refresh16;
        wr(2'd3, 4'b0011, 32'h0000A602);
        wr(2'd3, 4'b0011, 32'h0000B480);
    endtask

    // counts falling edges after the refresh edge; first pulse due on tout+1
    task automatic measure(input int tout, input string req);
        int first = -1;
        int extra = 0;
        for (int i = 1; i <= tout + 2; i++) begin
            @(negedge clk);
            if (wdt_rst_o) begin
                if (first < 0) first = i;
                else extra++;
            end
        end
        check(first == tout + 1 && extra == 0, req, 32'(first), 32'(tout + 1));
    endtask

    initial begin
        idle(4);
        rst = 1'b0;

        // R1 reset state
        expect_reg(2'd0, 32'h11, "R1");
        expect_reg(2'd1, 32'(DEF_TOVAL), "R1");
        expect_reg(2'd2, 32'h0, "R1");
        expect_reg(2'd3, 32'h0, "R1");

        // R2 / R9 timeout with reset defaults
        refresh16;
        measure(DEF_TOVAL, "R2");

        // R3 first configuration: run off, update-allow on
        wr(2'd0, 4'b1111, 32'h4);
        idle(2);
        expect_reg(2'd0, 32'h11, "R3");
        wr(2'd1, 4'b1111, 32'd60);
        idle(2);
        expect_reg(2'd0, 32'h24, "R3");
        expect_reg(2'd1, 32'd60, "R3");

        // R4 locked writes ignored
        wr(2'd1, 4'b1111, 32'd33);
        wr(2'd0, 4'b1111, 32'h1);
        wr(2'd2, 4'b1111, 32'd9);
        idle(2);
        expect_reg(2'd1, 32'd60, "R4");
        expect_reg(2'd0, 32'h24, "R4");
        expect_reg(2'd2, 32'd0, "R4");

        // R5 unlock with the second halfword exactly at the deadline
        b0 = bites;
        unlock16(DEADLINE);
        idle(2);
        expect_reg(2'd0, 32'h34, "R5");
        expect_bites(b0, "R5");

        // R3 window mode needs the window register too
        wr(2'd0, 4'b1111, 32'h7);
        wr(2'd1, 4'b1111, 32'd100);
        idle(2);
        expect_reg(2'd0, 32'h34, "R3");
        wr(2'd2, 4'b1111, 32'd40);
        idle(2);
        expect_reg(2'd0, 32'h27, "R3");
        expect_reg(2'd2, 32'd40, "R3");
        expect_reg(2'd1, 32'd100, "R3");

        // R10 early refresh bites, late refresh does not
        b0 = bites;
        refresh16;
        idle(2);
        expect_bites(b0 + 1, "R10");
        idle(50);
        b0 = bites;
        wr(2'd3, 4'b0011, 32'h0000A602);
        wr(2'd3, 4'b1100, 32'hB4800000);
        check(bites == b0 && !wdt_rst_o, "R10", 32'(bites), 32'(b0));
        measure(100, "R9");

        // switch to full-word commands, run off
        unlock16(1);
        wr(2'd0, 4'b1111, 32'hC);
        wr(2'd1, 4'b1111, 32'd50);
        idle(2);
        expect_reg(2'd0, 32'h2C, "R7");

        // R7 halfword key in full-word mode bites
        b0 = bites;
        wr(2'd3, 4'b0011, 32'h0000C520);
        idle(2);
        expect_bites(b0 + 1, "R7");
        b0 = bites;
        wr(2'd3, 4'b1111, 32'hD928C520);
        idle(2);
        expect_reg(2'd0, 32'h3C, "R7");
        expect_bites(b0, "R7");
        wr(2'd0, 4'b1111, 32'hD);
        wr(2'd1, 4'b1111, 32'd50);
        idle(2);
        expect_reg(2'd0, 32'h2D, "R7");
        wr(2'd3, 4'b1111, 32'hB480A602);
        measure(50, "R9");

        // back to halfword mode, run off
        wr(2'd3, 4'b1111, 32'hD928C520);
        wr(2'd0, 4'b1111, 32'h4);
        wr(2'd1, 4'b1111, 32'd60);
        idle(2);
        expect_reg(2'd0, 32'h24, "R6");

        // R6 key faults
        b0 = bites;
        wr(2'd3, 4'b0011, 32'h00001234);
        idle(2);
        expect_bites(b0 + 1, "R6");
        b0 = bites;
        wr(2'd3, 4'b0011, 32'h0000D928);
        idle(2);
        expect_bites(b0 + 1, "R6");
        b0 = bites;
        unlock16(DEADLINE + 1);
        idle(2);
        expect_bites(b0 + 2, "R6");
        expect_reg(2'd0, 32'h24, "R6");
        b0 = bites;
        wr(2'd3, 4'b0011, 32'h0000C520);
        wr(2'd3, 4'b0011, 32'h0000B480);
        idle(2);
        expect_bites(b0 + 1, "R6");
        b0 = bites;
        wr(2'd3, 4'b1111, 32'hD928C520);
        idle(2);
        expect_bites(b0 + 1, "R6");
        expect_reg(2'd0, 32'h24, "R6");

        // R8 unlock window lapses
        unlock16(1);
        idle(2);
        expect_reg(2'd0, 32'h34, "R8");
        wr(2'd1, 4'b1111, 32'd77);
        idle(100);
        expect_reg(2'd0, 32'h34, "R8");
        idle(40);
        expect_reg(2'd0, 32'h24, "R8");
        expect_reg(2'd1, 32'd60, "R8");

        // R11 commit without update-allow, then unlock is refused
        unlock16(1);
        wr(2'd0, 4'b1111, 32'h0);
        wr(2'd1, 4'b1111, 32'd60);
        idle(2);
        expect_reg(2'd0, 32'h20, "R11");
        b0 = bites;
        unlock16(1);
        idle(2);
        expect_bites(b0 + 1, "R11");
        expect_reg(2'd0, 32'h20, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule